// File: doc/BRIEF.md
# Power-Fail Self-Refresh Sequencer

This block is a fixed, one-shot command sequencer for a DDR4 memory channel. When a power-fail warning arrives, it parks the DRAM safely so that a non-volatile module can save its contents. Software arms the block once DRAM initialisation has finished. From then on, a single trigger starts a four-step sequence:

1. A deselect period that covers any refresh still in flight (tRFC).
2. A broadcast precharge-all, followed by its recovery wait (tRP).
3. A broadcast self-refresh entry, followed by its wait (tCKSRE).
4. A final hold state with CKE low and the DRAM reset asserted. The block never leaves this state until a system reset.

Before the trigger, the block does not own the pins. Its `drive_en_o` output tells the pin multiplexer to keep routing normal controller traffic. From the first sequence cycle onward, `drive_en_o` stays high. All chip selects are driven as one group: ranks 0–1 and ranks 2–3 are both active (2'b00) together. The wait lengths are given in clock cycles and are captured when the trigger is accepted.

Top module: `pf_sr_seq`

## Requirements
- R1: After `rst_ni` is released and before a trigger is accepted, `drive_en_o`=0, `done_o`=0, `reset_n_o`=1, all `cke_o`=1, all `cs_n_o`=1, and `act_n_o`/`ras_n_o`/`cas_n_o`/`we_n_o`=1 with `a10_o`=0.
- R2: `trig_i` is accepted only if `arm_i` was high on some earlier clock edge since reset. A trigger in the same cycle as the first arm pulse, or with no arm at all, leaves all outputs at their R1 values.
- R3: A trigger accepted at edge E is followed, starting in the cycle after E, by tRFC+1 deselect cycles. In these cycles CKE=1, every CS_n=1, RESET_n=1, ACT_n/RAS_n/CAS_n/WE_n=1 and A10=0.
- R4: Next comes one precharge-all cycle. Every CS_n=0, CKE=1, ACT_n=1, RAS_n=0, CAS_n=1, WE_n=0, A10=1 and RESET_n=1. It is followed by tRP deselect cycles with CKE=1.
- R5: Next comes one self-refresh entry cycle. Every CS_n=0, every CKE=0, ACT_n=1, RAS_n=0, CAS_n=0, WE_n=1 and RESET_n=1. It is followed by tCKSRE cycles with CKE=0, every CS_n=1 and command pins high.
- R6: Next the block enters the hold state: RESET_n=0, CKE=0, every CS_n=1 and `done_o`=1. It stays there until `rst_ni`, whatever `trig_i`, `arm_i` or the timing inputs do.
- R7: The three timing inputs are sampled at the trigger edge. Changing them afterwards does not alter the sequence.
- R8: `drive_en_o` is 0 before the first deselect cycle and 1 from that cycle on.
- R9: Timing values of zero give one cycle per step. The sequence then reaches the hold state in the fourth cycle after the trigger edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | DRAM command clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| arm_i | input | 1 | Arms the sequencer; level sampled each edge |
| trig_i | input | 1 | Power-fail trigger |
| t_rfc_i | input | 16 | Refresh-completion wait, in cycles |
| t_rp_i | input | 8 | Precharge recovery wait, in cycles |
| t_cksre_i | input | 8 | Self-refresh entry wait, in cycles |
| drive_en_o | output | 1 | Selects this block on the DRAM pin mux |
| done_o | output | 1 | Hold state reached |
| reset_n_o | output | 1 | DRAM RESET_n |
| cke_o | output | 2 | DRAM clock enables |
| cs_n_o | output | 4 | Chip selects, ranks 0..3 |
| act_n_o | output | 1 | ACT_n command pin |
| ras_n_o | output | 1 | RAS_n command pin |
| cas_n_o | output | 1 | CAS_n command pin |
| we_n_o | output | 1 | WE_n command pin |
| a10_o | output | 1 | Address bit 10 (all-bank flag) |

## Verification
The bench builds the block with the default widths: a 16-bit tRFC, 8-bit tRP and tCKSRE, four ranks and two CKE lines. This lets directed tests use zero waits and a tRFC above 255, which exercises the wider counter path beyond the 8-bit range. Random runs draw small waits from a fixed seed so that many complete sequences fit in the run. Every cycle is compared against a per-offset expected pin vector. Dedicated cases cover an unarmed trigger, a trigger that coincides with arming, timing inputs scrambled mid-sequence, and triggers repeated during the hold state.

// File: rtl/pf_sr_pkg.sv
package pf_sr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DES, ST_PRE, ST_SRE, ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic act_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } cmd_t;

  localparam cmd_t CMD_NOP = '{act_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam cmd_t CMD_PREA = '{act_n: 1'b1, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam cmd_t CMD_SRE = '{act_n: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
endpackage

// File: rtl/pf_sr_arm.sv
module pf_sr_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic trig_i,
  input  logic idle_i,
  output logic start_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  // armed must predate the trigger edge
  assign start_o = armed_q & trig_i & idle_i;
endmodule

// File: rtl/pf_sr_timer.sv
module pf_sr_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pf_sr_fsm.sv
module pf_sr_fsm
  import pf_sr_pkg::*;
#(
  parameter int unsigned RFC_W   = 16,
  parameter int unsigned RP_W    = 8,
  parameter int unsigned CKSRE_W = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RFC_W-1:0]   t_rfc_i,
  input  logic [RP_W-1:0]    t_rp_i,
  input  logic [CKSRE_W-1:0] t_cksre_i,
  input  logic               zero_i,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output seq_st_e            st_o,
  output logic               first_o
);
  seq_st_e             st_q, st_d;
  logic                first_q;
  logic [RP_W-1:0]     rp_q;
  logic [CKSRE_W-1:0]  cksre_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_DES; load_o = 1'b1; load_val_o = CNT_W'(t_rfc_i);
      end
      ST_DES: if (zero_i) begin
        st_d = ST_PRE; load_o = 1'b1; load_val_o = CNT_W'(rp_q);
      end
      ST_PRE: if (zero_i) begin
        st_d = ST_SRE; load_o = 1'b1; load_val_o = CNT_W'(cksre_q);
      end
      ST_SRE: if (zero_i) st_d = ST_HOLD;
      default: st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      rp_q    <= '0;
      cksre_q <= '0;
    end else begin
      st_q    <= st_d;
      first_q <= (st_d != st_q);
      if (st_q == ST_IDLE && start_i) begin
        rp_q    <= t_rp_i;
        cksre_q <= t_cksre_i;
      end
    end
  end

  assign st_o    = st_q;
  assign first_o = first_q;
endmodule

// File: rtl/pf_sr_pins.sv
module pf_sr_pins
  import pf_sr_pkg::*;
#(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned CKE_W     = 2
) (
  input  seq_st_e              st_i,
  input  logic                 first_i,
  output logic                 drive_en_o,
  output logic                 done_o,
  output logic                 reset_n_o,
  output logic [CKE_W-1:0]     cke_o,
  output logic [NUM_RANKS-1:0] cs_n_o,
  output cmd_t                 cmd_o
);
  logic cs_act, cke_hi;

  always_comb begin
    cs_act = 1'b0;
    cke_hi = 1'b1;
    cmd_o  = CMD_NOP;
    unique case (st_i)
      ST_PRE: if (first_i) begin cs_act = 1'b1; cmd_o = CMD_PREA; end
      ST_SRE: begin
        cke_hi = 1'b0;
        if (first_i) begin cs_act = 1'b1; cmd_o = CMD_SRE; end
      end
      ST_HOLD: cke_hi = 1'b0;
      default: ;
    endcase
  end

  // broadcast: every rank group sees the same select
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
    assign cs_n_o[r] = ~cs_act;
  end
  for (genvar c = 0; c < CKE_W; c++) begin : g_cke
    assign cke_o[c] = cke_hi;
  end

  assign drive_en_o = (st_i != ST_IDLE);
  assign done_o     = (st_i == ST_HOLD);
  assign reset_n_o  = (st_i != ST_HOLD);
endmodule

// File: rtl/pf_sr_seq.sv
module pf_sr_seq
  import pf_sr_pkg::*;
#(
  parameter int unsigned RFC_W     = 16,
  parameter int unsigned RP_W      = 8,
  parameter int unsigned CKSRE_W   = 8,
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned CKE_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic                 trig_i,
  input  logic [RFC_W-1:0]     t_rfc_i,
  input  logic [RP_W-1:0]      t_rp_i,
  input  logic [CKSRE_W-1:0]   t_cksre_i,
  output logic                 drive_en_o,
  output logic                 done_o,
  output logic                 reset_n_o,
  output logic [CKE_W-1:0]     cke_o,
  output logic [NUM_RANKS-1:0] cs_n_o,
  output logic                 act_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 a10_o
);
  localparam int unsigned SHORT_W = (RP_W > CKSRE_W) ? RP_W : CKSRE_W;
  localparam int unsigned CNT_W   = (RFC_W > SHORT_W) ? RFC_W : SHORT_W;

  seq_st_e          st;
  logic             first, start, load, zero;
  logic [CNT_W-1:0] load_val;
  cmd_t             cmd;

  pf_sr_arm u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .trig_i(trig_i),
    .idle_i(st == ST_IDLE), .start_o(start)
  );

  pf_sr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(load_val),
    .zero_o(zero)
  );

  pf_sr_fsm #(
    .RFC_W(RFC_W), .RP_W(RP_W), .CKSRE_W(CKSRE_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .t_rfc_i(t_rfc_i), .t_rp_i(t_rp_i), .t_cksre_i(t_cksre_i),
    .zero_i(zero), .load_o(load), .load_val_o(load_val),
    .st_o(st), .first_o(first)
  );

  pf_sr_pins #(.NUM_RANKS(NUM_RANKS), .CKE_W(CKE_W)) u_pins (
    .st_i(st), .first_i(first), .drive_en_o(drive_en_o), .done_o(done_o),
    .reset_n_o(reset_n_o), .cke_o(cke_o), .cs_n_o(cs_n_o), .cmd_o(cmd)
  );

  assign act_n_o = cmd.act_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign a10_o   = cmd.a10;
endmodule

// File: rtl/pf_sr_seq_chk.sv
module pf_sr_seq_chk #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned CKE_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 drive_en_o,
  input logic                 done_o,
  input logic                 reset_n_o,
  input logic [CKE_W-1:0]     cke_o,
  input logic [NUM_RANKS-1:0] cs_n_o,
  input logic                 act_n_o,
  input logic                 ras_n_o,
  input logic                 cas_n_o,
  input logic                 we_n_o,
  input logic                 a10_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_en_o |-> reset_n_o && (&cs_n_o) && (&cke_o) && !done_o);

  p_cs_broadcast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_o == '0) || (cs_n_o == '1));

  p_prea_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o[0] && cke_o[0]) |-> act_n_o && !ras_n_o && cas_n_o && !we_n_o && a10_o);

  p_sre_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o[0] && !cke_o[0]) |-> act_n_o && !ras_n_o && !cas_n_o && we_n_o);

  p_cke_fall_sre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o[0]) |-> (cs_n_o == '0) && reset_n_o);

  p_hold_pins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_n_o |-> (cke_o == '0) && (&cs_n_o) && done_o);

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !reset_n_o);

  p_drive_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |=> drive_en_o);
endmodule

bind pf_sr_seq pf_sr_seq_chk #(.NUM_RANKS(NUM_RANKS), .CKE_W(CKE_W)) u_chk (.*);

// File: tb/pf_sr_seq_tb.sv
module pf_sr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, trig = 1'b0;
  logic [15:0] t_rfc = '0;
  logic [7:0]  t_rp = '0, t_cksre = '0;
  logic        drive_en, done, reset_n, act_n, ras_n, cas_n, we_n, a10;
  logic [1:0]  cke;
  logic [3:0]  cs_n;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  localparam logic [14:0] V_IDLE = {3'b001, 2'b11, 4'hF, 5'b11110};
  localparam logic [14:0] V_DES  = {3'b101, 2'b11, 4'hF, 5'b11110};
  localparam logic [14:0] V_PRE  = {3'b101, 2'b11, 4'h0, 5'b10101};
  localparam logic [14:0] V_SRE  = {3'b101, 2'b00, 4'h0, 5'b10010};
  localparam logic [14:0] V_SRW  = {3'b101, 2'b00, 4'hF, 5'b11110};
  localparam logic [14:0] V_HOLD = {3'b110, 2'b00, 4'hF, 5'b11110};

  always #4 clk = ~clk;

  pf_sr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig),
    .t_rfc_i(t_rfc), .t_rp_i(t_rp), .t_cksre_i(t_cksre),
    .drive_en_o(drive_en), .done_o(done), .reset_n_o(reset_n), .cke_o(cke),
    .cs_n_o(cs_n), .act_n_o(act_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .a10_o(a10)
  );

  function automatic logic [14:0] obs();
    return {drive_en, done, reset_n, cke, cs_n, act_n, ras_n, cas_n, we_n, a10};
  endfunction

  // expected pins at offset k after the trigger edge (k=0 is first DES cycle)
  function automatic logic [14:0] exp_at(int k, int rfc, int rp, int ck);
    if (k <= rfc) return V_DES;
    k -= rfc + 1;
    if (k == 0) return V_PRE;
    if (k <= rp) return V_DES;
    k -= rp + 1;
    if (k == 0) return V_SRE;
    if (k <= ck) return V_SRW;
    return V_HOLD;
  endfunction

  function automatic string req_of(int k, int rfc, int rp, int ck);
    if (k <= rfc) return "R3";
    if (k <= rfc + rp + 1) return "R4";
    if (k <= rfc + rp + ck + 2) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; arm = 1'b0; trig = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // arm, trigger, then compare every cycle; optionally scramble timings (R7)
  task automatic run_seq(int rfc, int rp, int ck, bit scramble, int tail, string tag);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    check("R8", obs(), V_IDLE);
    t_rfc = 16'(rfc); t_rp = 8'(rp); t_cksre = 8'(ck); trig = 1'b1;
    for (int k = 0; k < rfc + rp + ck + 3 + tail; k++) begin
      @(negedge clk);
      if (k == 0) trig = 1'b0;
      if (scramble) begin
        t_rfc = 16'($urandom); t_rp = 8'($urandom); t_cksre = 8'($urandom);
      end
      // R6: re-trigger and re-arm in hold must not change anything
      if (k > rfc + rp + ck + 3) begin trig = k[0]; arm = k[1]; end
      check(scramble ? "R7" : (tag != "" ? tag : req_of(k, rfc, rp, ck)),
            obs(), exp_at(k, rfc, rp, ck));
    end
    trig = 1'b0; arm = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    check("R1", obs(), V_IDLE);

    // R2: unarmed trigger ignored
    trig = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2", obs(), V_IDLE);
    end
    // R2: trigger coinciding with first arm ignored
    do_reset();
    arm = 1'b1; trig = 1'b1;
    @(negedge clk);
    arm = 1'b0; trig = 1'b0;
    @(negedge clk);
    check("R2", obs(), V_IDLE);
    @(negedge clk);
    check("R2", obs(), V_IDLE);

    // R9: zero waits
    do_reset();
    run_seq(0, 0, 0, 1'b0, 10, "R9");
    // R3: tRFC beyond 8 bits
    do_reset();
    run_seq(300, 3, 2, 1'b0, 6, "");
    // R7: scrambled timing inputs after trigger
    do_reset();
    run_seq(5, 4, 3, 1'b1, 6, "");
    // R6: long hold
    do_reset();
    run_seq(1, 1, 1, 1'b0, 60, "R6");
    // random runs
    for (int n = 0; n < 8; n++) begin
      do_reset();
      run_seq(int'($urandom_range(0, 40)), int'($urandom_range(0, 20)),
              int'($urandom_range(0, 20)), 1'b0, 8, "");
    end
    // R1: reset from hold returns to idle
    rst_n = 1'b0;
    #1;
    check("R1", obs(), V_IDLE);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule